// File: doc/BRIEF.md
# CCD frame readout sequencer

A free-running pixel-rate state machine that walks an interline CCD through one image frame at a time. Each frame starts with a one-cycle clear. On selected frames the photodiode charge is then moved into the vertical registers. Rows are shifted down by vertical periods and read out pixel by pixel. Optional rows are dumped quickly at the top and bottom of the image. An electronic shutter pulse can also be placed on a chosen line. The block drives the vertical clocks, the third-level transfer control and the horizontal clock enable. It also drives the shutter pulse, frame/line/pixel sync strobes for a capture device, and an integration flag.

Three mode selects pick the readout style: dual output, fast dump and 2x2 binning. A 3-bit select stretches integration over several frames, and a 3-bit select places the shutter. All selects are sampled once per frame, in the clear state. Every count (phase lengths, pixels per line, lines per frame, dumped rows, shutter step) is a parameter, so the sequencer can be simulated at reduced size.

Top module: `ccd_frame_seq`

## Requirements
- R1: Resolved mode: dual is taken as given; binning is active only without dual; fast dump is active only when binning is not active. So binning+fast gives plain binning, binning+dual gives dual, and all three give dual with fast dump.
- R2: A photodiode transfer lasts SETUP_CNT+V3RD_CNT+DELAY_CNT cycles. `v3rd_o` and `vclk1_o` are high for exactly V3RD_CNT cycles in its middle, and for no other cycles.
- R3: With integration select N (0..7), a photodiode transfer happens on one frame out of every N+1. Frames without it are one clear cycle plus the readout.
- R4: Every vertical period (readout or dump) lasts VDLY_CNT+VCCD_CNT+HDLY_CNT cycles. `vclk2_o` is high for exactly VCCD_CNT consecutive cycles in it.
- R5: Each line readout lasts PIX_CNT cycles with `hclk_en_o` and `line_sync_o` high. Without fast dump, a frame reads LINES lines in single mode and LINES/2 in dual or binning mode.
- R6: In dual and binning modes, two vertical periods precede each line readout. In single mode there is one.
- R7: With fast dump resolved, DUMP_LINES rows are dumped before the first readout and DUMP_LINES after the last. Each dumped row takes one vertical period with `hclk_en_o` low. The frame reads (LINES-2*DUMP_LINES) lines, halved in dual mode.
- R8: `frame_sync_o` is high from the first readout vertical period to the end of the last line. A frame lasts 1 + transfer + dumps + lines*(vertical periods+PIX_CNT) + shutter cycles.
- R9: With shutter select M (1..7), the shutter phase is entered after line STEP*M has been read and before the next line. `shutter_o` is high for SHUT_PULSE cycles, followed by SHUT_DELAY idle cycles. M=0 gives no shutter.
- R10: A shutter line STEP*M not below the frame's read line count produces no shutter (for example M=4 in dual mode with LINES=16, STEP=2).
- R11: `pix_sync_o` is high on every readout cycle in single and dual modes. In binning mode it is high only on even pixel counts (0, 2, 4, ...).
- R12: `integrate_o` is low during the photodiode transfer and the shutter phase, high at all other times after the first transfer, and low from reset until then.
- R13: Synchronous active-high reset drives all outputs low. Mode, integration and shutter selects are sampled only in the clear state, so a change during a frame applies from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| dual_sel_i | input | 1 | Request dual output readout |
| fdump_sel_i | input | 1 | Request fast dump of top and bottom rows |
| bin_sel_i | input | 1 | Request 2x2 binning |
| int_sel_i | input | 3 | Multi-frame integration select N |
| shut_sel_i | input | 3 | Shutter line select M (0 = off) |
| vclk1_o | output | 1 | First vertical clock, high during photodiode transfer |
| vclk2_o | output | 1 | Second vertical clock, pulses once per vertical period |
| v3rd_o | output | 1 | Third-level transfer control |
| hclk_en_o | output | 1 | Horizontal clock enable |
| shutter_o | output | 1 | Electronic shutter pulse |
| frame_sync_o | output | 1 | Frame strobe over the active lines |
| line_sync_o | output | 1 | Line strobe over each readout |
| pix_sync_o | output | 1 | Pixel strobe |
| integrate_o | output | 1 | High while charge integrates |

## Verification
The assertions take the select inputs to be known values after reset. They also take the parameters to be consistent: LINES-2*DUMP_LINES even, DUMP_LINES and PIX_CNT at least one, PIX_CNT even. With those in place, fixed phase lengths and the exclusion of vertical, horizontal and shutter activity hold in every mode. The bench sets all selects while reset is held and releases reset only afterwards. It changes a select mid-frame in one scenario only, to show that the change waits for the next clear state. Reduced parameter values keep every combination of modes within a few hundred cycles per frame.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_DIODE = 3'd1,
    ST_ESHUT = 3'd2,
    ST_VXFER = 3'd3,
    ST_DUALX = 3'd4,
    ST_LINE  = 3'd5,
    ST_FDUMP = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic dual;
    logic bin;
    logic fdump;
  } seq_mode_t;

endpackage

// File: rtl/seq_mode_resolve.sv
module seq_mode_resolve
  import ccd_seq_pkg::*;
#(
  parameter int LINES      = 496,
  parameter int DUMP_LINES = 100,
  parameter int SHUT_STEP  = 62,
  parameter int LN_W       = 9,
  parameter int SL_W       = 12
) (
  input  logic            dual_i,
  input  logic            fdump_i,
  input  logic            bin_i,
  input  logic [2:0]      shut_sel_i,
  output seq_mode_t       mode_o,
  output logic [LN_W-1:0] read_lines_o,
  output logic [SL_W-1:0] shut_line_o,
  output logic            shut_en_o
);
  // read line counts for each resolved mode
  localparam logic [LN_W-1:0] RL_FULL    = LN_W'(LINES);
  localparam logic [LN_W-1:0] RL_HALF    = LN_W'(LINES / 2);
  localparam logic [LN_W-1:0] RL_FD_FULL = LN_W'(LINES - 2 * DUMP_LINES);
  localparam logic [LN_W-1:0] RL_FD_HALF = LN_W'((LINES - 2 * DUMP_LINES) / 2);

  // dual beats binning, binning beats fast dump
  always_comb begin
    mode_o.dual  = dual_i;
    mode_o.bin   = bin_i & ~dual_i;
    mode_o.fdump = fdump_i & ~(bin_i & ~dual_i);
  end

  always_comb begin
    unique case ({mode_o.fdump, (mode_o.dual | mode_o.bin)})
      2'b00:   read_lines_o = RL_FULL;
      2'b01:   read_lines_o = RL_HALF;
      2'b10:   read_lines_o = RL_FD_FULL;
      default: read_lines_o = RL_FD_HALF;
    endcase
  end

  always_comb begin
    shut_line_o = SL_W'(shut_sel_i) * SL_W'(SHUT_STEP);
    shut_en_o   = (shut_sel_i != 3'd0) &&
                  (shut_line_o < {3'b000, read_lines_o});
  end

endmodule

// File: rtl/seq_frame_fsm.sv
module seq_frame_fsm
  import ccd_seq_pkg::*;
#(
  parameter int SETUP_CNT  = 301,
  parameter int V3RD_CNT   = 120,
  parameter int DELAY_CNT  = 301,
  parameter int VDLY_CNT   = 2,
  parameter int VCCD_CNT   = 62,
  parameter int HDLY_CNT   = 62,
  parameter int PIX_CNT    = 708,
  parameter int DUMP_LINES = 100,
  parameter int SHUT_PULSE = 750,
  parameter int SHUT_DELAY = 150,
  parameter int PH_W       = 10,
  parameter int LN_W       = 9,
  parameter int SL_W       = 12,
  parameter int DC_W       = 7
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  seq_mode_t       mode_i,
  input  logic [LN_W-1:0] read_lines_i,
  input  logic [SL_W-1:0] shut_line_i,
  input  logic            shut_en_i,
  input  logic [2:0]      int_sel_i,
  output seq_state_e      state_o,
  output logic [PH_W-1:0] phase_o,
  output logic            act_bin_o
);
  localparam int DIODE_LEN = SETUP_CNT + V3RD_CNT + DELAY_CNT;
  localparam int VPER_LEN  = VDLY_CNT + VCCD_CNT + HDLY_CNT;
  localparam int SHUT_LEN  = SHUT_PULSE + SHUT_DELAY;

  localparam logic [PH_W-1:0] DIODE_LAST = PH_W'(DIODE_LEN - 1);
  localparam logic [PH_W-1:0] VPER_LAST  = PH_W'(VPER_LEN - 1);
  localparam logic [PH_W-1:0] SHUT_LAST  = PH_W'(SHUT_LEN - 1);
  localparam logic [PH_W-1:0] LINE_LAST  = PH_W'(PIX_CNT - 1);
  localparam logic [DC_W-1:0] DUMP_LAST  = DC_W'(DUMP_LINES - 1);

  seq_state_e      state_q;
  logic [PH_W-1:0] ph_q;
  logic [LN_W-1:0] ln_q;
  logic [DC_W-1:0] dc_q;
  logic            second_q;
  logic            tail_q;
  logic [2:0]      frm_q;
  seq_mode_t       mode_q;
  logic [LN_W-1:0] rl_q;
  logic [SL_W-1:0] sl_q;
  logic            sen_q;

  logic [PH_W-1:0] ph_last;
  logic            ph_end;
  logic            shut_hit;
  logic            last_line;

  always_comb begin
    unique case (state_q)
      ST_DIODE: ph_last = DIODE_LAST;
      ST_ESHUT: ph_last = SHUT_LAST;
      ST_LINE:  ph_last = LINE_LAST;
      ST_VXFER, ST_DUALX, ST_FDUMP: ph_last = VPER_LAST;
      default:  ph_last = '0;
    endcase
    ph_end    = (ph_q == ph_last);
    shut_hit  = sen_q && ({3'b000, ln_q} == sl_q);
    last_line = (ln_q == rl_q - LN_W'(1));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q  <= ST_CLEAR;
      ph_q     <= '0;
      ln_q     <= '0;
      dc_q     <= '0;
      second_q <= 1'b0;
      tail_q   <= 1'b0;
      frm_q    <= 3'd0;
      mode_q   <= '0;
      rl_q     <= '0;
      sl_q     <= '0;
      sen_q    <= 1'b0;
    end else if (state_q == ST_CLEAR) begin
      // new frame: counters cleared, selects captured
      ph_q     <= '0;
      ln_q     <= '0;
      dc_q     <= '0;
      second_q <= 1'b0;
      tail_q   <= 1'b0;
      mode_q   <= mode_i;
      rl_q     <= read_lines_i;
      sl_q     <= shut_line_i;
      sen_q    <= shut_en_i;
      frm_q    <= (frm_q >= int_sel_i) ? 3'd0 : frm_q + 3'd1;
      if (frm_q == 3'd0)     state_q <= ST_DIODE;
      else if (mode_i.fdump) state_q <= ST_FDUMP;
      else                   state_q <= ST_VXFER;
    end else if (!ph_end) begin
      ph_q <= ph_q + PH_W'(1);
    end else begin
      ph_q <= '0;
      unique case (state_q)
        ST_DIODE: state_q <= mode_q.fdump ? ST_FDUMP : ST_VXFER;
        ST_FDUMP: begin
          if (dc_q == DUMP_LAST) begin
            dc_q    <= '0;
            state_q <= tail_q ? ST_CLEAR : ST_VXFER;
          end else begin
            dc_q <= dc_q + DC_W'(1);
          end
        end
        ST_VXFER: begin
          if ((mode_q.dual | mode_q.bin) && !second_q) begin
            second_q <= 1'b1;
            state_q  <= mode_q.dual ? ST_DUALX : ST_VXFER;
          end else begin
            second_q <= 1'b0;
            state_q  <= shut_hit ? ST_ESHUT : ST_LINE;
          end
        end
        ST_DUALX: begin
          second_q <= 1'b0;
          state_q  <= shut_hit ? ST_ESHUT : ST_LINE;
        end
        ST_ESHUT: state_q <= ST_LINE;
        ST_LINE: begin
          ln_q <= ln_q + LN_W'(1);
          if (last_line) begin
            if (mode_q.fdump) begin
              tail_q  <= 1'b1;
              state_q <= ST_FDUMP;
            end else begin
              state_q <= ST_CLEAR;
            end
          end else begin
            state_q <= ST_VXFER;
          end
        end
        default: state_q <= ST_CLEAR;
      endcase
    end
  end

  assign state_o   = state_q;
  assign phase_o   = ph_q;
  assign act_bin_o = mode_q.bin;

endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
  import ccd_seq_pkg::*;
#(
  parameter int SETUP_CNT  = 301,
  parameter int V3RD_CNT   = 120,
  parameter int VDLY_CNT   = 2,
  parameter int VCCD_CNT   = 62,
  parameter int SHUT_PULSE = 750,
  parameter int PH_W       = 10
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  seq_state_e      state_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic            bin_i,
  output logic            vclk1_o,
  output logic            vclk2_o,
  output logic            v3rd_o,
  output logic            hclk_en_o,
  output logic            shutter_o,
  output logic            frame_sync_o,
  output logic            line_sync_o,
  output logic            pix_sync_o,
  output logic            integrate_o
);
  localparam logic [PH_W-1:0] V3_LO = PH_W'(SETUP_CNT);
  localparam logic [PH_W-1:0] V3_HI = PH_W'(SETUP_CNT + V3RD_CNT);
  localparam logic [PH_W-1:0] V2_LO = PH_W'(VDLY_CNT);
  localparam logic [PH_W-1:0] V2_HI = PH_W'(VDLY_CNT + VCCD_CNT);
  localparam logic [PH_W-1:0] SH_HI = PH_W'(SHUT_PULSE);

  logic in_diode, in_vper, in_line, in_eshut, in_frame;
  logic seen_q;

  always_comb begin
    in_diode = (state_i == ST_DIODE);
    in_eshut = (state_i == ST_ESHUT);
    in_line  = (state_i == ST_LINE);
    in_vper  = (state_i == ST_VXFER) || (state_i == ST_DUALX) ||
               (state_i == ST_FDUMP);
    in_frame = (state_i == ST_VXFER) || (state_i == ST_DUALX) ||
               in_eshut || in_line;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vclk1_o      <= 1'b0;
      vclk2_o      <= 1'b0;
      v3rd_o       <= 1'b0;
      hclk_en_o    <= 1'b0;
      shutter_o    <= 1'b0;
      frame_sync_o <= 1'b0;
      line_sync_o  <= 1'b0;
      pix_sync_o   <= 1'b0;
      integrate_o  <= 1'b0;
      seen_q       <= 1'b0;
    end else begin
      vclk1_o      <= in_diode && (phase_i >= V3_LO) && (phase_i < V3_HI);
      v3rd_o       <= in_diode && (phase_i >= V3_LO) && (phase_i < V3_HI);
      vclk2_o      <= in_vper && (phase_i >= V2_LO) && (phase_i < V2_HI);
      hclk_en_o    <= in_line;
      line_sync_o  <= in_line;
      pix_sync_o   <= in_line && (!bin_i || !phase_i[0]);
      shutter_o    <= in_eshut && (phase_i < SH_HI);
      frame_sync_o <= in_frame;
      seen_q       <= seen_q | in_diode;
      integrate_o  <= seen_q && !in_diode && !in_eshut;
    end
  end

endmodule

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq
  import ccd_seq_pkg::*;
#(
  parameter int SETUP_CNT  = 301,
  parameter int V3RD_CNT   = 120,
  parameter int DELAY_CNT  = 301,
  parameter int VDLY_CNT   = 2,
  parameter int VCCD_CNT   = 62,
  parameter int HDLY_CNT   = 62,
  parameter int PIX_CNT    = 708,
  parameter int LINES      = 496,
  parameter int DUMP_LINES = 100,
  parameter int SHUT_STEP  = 62,
  parameter int SHUT_PULSE = 750,
  parameter int SHUT_DELAY = 150
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       dual_sel_i,
  input  logic       fdump_sel_i,
  input  logic       bin_sel_i,
  input  logic [2:0] int_sel_i,
  input  logic [2:0] shut_sel_i,
  output logic       vclk1_o,
  output logic       vclk2_o,
  output logic       v3rd_o,
  output logic       hclk_en_o,
  output logic       shutter_o,
  output logic       frame_sync_o,
  output logic       line_sync_o,
  output logic       pix_sync_o,
  output logic       integrate_o
);
  localparam int DIODE_LEN = SETUP_CNT + V3RD_CNT + DELAY_CNT;
  localparam int VPER_LEN  = VDLY_CNT + VCCD_CNT + HDLY_CNT;
  localparam int SHUT_LEN  = SHUT_PULSE + SHUT_DELAY;
  localparam int MAX_AB    = (DIODE_LEN > VPER_LEN) ? DIODE_LEN : VPER_LEN;
  localparam int MAX_CD    = (SHUT_LEN > PIX_CNT) ? SHUT_LEN : PIX_CNT;
  localparam int MAX_PH    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int PH_W      = $clog2(MAX_PH + 1);
  localparam int LN_W      = $clog2(LINES + 1);
  localparam int SL_W      = LN_W + 3;
  localparam int DC_W      = $clog2(DUMP_LINES + 1);

  seq_mode_t       res_mode;
  logic [LN_W-1:0] read_lines;
  logic [SL_W-1:0] shut_line;
  logic            shut_en;
  seq_state_e      state;
  logic [PH_W-1:0] phase;
  logic            act_bin;

  seq_mode_resolve #(
    .LINES(LINES), .DUMP_LINES(DUMP_LINES), .SHUT_STEP(SHUT_STEP),
    .LN_W(LN_W), .SL_W(SL_W)
  ) u_resolve (
    .dual_i      (dual_sel_i),
    .fdump_i     (fdump_sel_i),
    .bin_i       (bin_sel_i),
    .shut_sel_i  (shut_sel_i),
    .mode_o      (res_mode),
    .read_lines_o(read_lines),
    .shut_line_o (shut_line),
    .shut_en_o   (shut_en)
  );

  seq_frame_fsm #(
    .SETUP_CNT(SETUP_CNT), .V3RD_CNT(V3RD_CNT), .DELAY_CNT(DELAY_CNT),
    .VDLY_CNT(VDLY_CNT), .VCCD_CNT(VCCD_CNT), .HDLY_CNT(HDLY_CNT),
    .PIX_CNT(PIX_CNT), .DUMP_LINES(DUMP_LINES),
    .SHUT_PULSE(SHUT_PULSE), .SHUT_DELAY(SHUT_DELAY),
    .PH_W(PH_W), .LN_W(LN_W), .SL_W(SL_W), .DC_W(DC_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .mode_i      (res_mode),
    .read_lines_i(read_lines),
    .shut_line_i (shut_line),
    .shut_en_i   (shut_en),
    .int_sel_i   (int_sel_i),
    .state_o     (state),
    .phase_o     (phase),
    .act_bin_o   (act_bin)
  );

  seq_out_decode #(
    .SETUP_CNT(SETUP_CNT), .V3RD_CNT(V3RD_CNT), .VDLY_CNT(VDLY_CNT),
    .VCCD_CNT(VCCD_CNT), .SHUT_PULSE(SHUT_PULSE), .PH_W(PH_W)
  ) u_decode (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .state_i     (state),
    .phase_i     (phase),
    .bin_i       (act_bin),
    .vclk1_o     (vclk1_o),
    .vclk2_o     (vclk2_o),
    .v3rd_o      (v3rd_o),
    .hclk_en_o   (hclk_en_o),
    .shutter_o   (shutter_o),
    .frame_sync_o(frame_sync_o),
    .line_sync_o (line_sync_o),
    .pix_sync_o  (pix_sync_o),
    .integrate_o (integrate_o)
  );

endmodule

// File: rtl/ccd_frame_seq_chk.sv
module ccd_frame_seq_chk #(
  parameter int VCCD_CNT   = 62,
  parameter int SHUT_PULSE = 750
) (
  input logic clk_i,
  input logic rst_i,
  input logic vclk1_o,
  input logic vclk2_o,
  input logic v3rd_o,
  input logic hclk_en_o,
  input logic shutter_o,
  input logic frame_sync_o,
  input logic line_sync_o,
  input logic pix_sync_o,
  input logic integrate_o,
  input logic res_dual,
  input logic res_bin,
  input logic res_fdump,
  input logic act_bin
);
  int unsigned v2_run_q;
  int unsigned sh_run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      v2_run_q <= 0;
      sh_run_q <= 0;
    end else begin
      v2_run_q <= vclk2_o ? v2_run_q + 1 : 0;
      sh_run_q <= shutter_o ? sh_run_q + 1 : 0;
    end
  end

  // R1: resolved modes never overlap
  p_mode_excl_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (res_dual |-> !res_bin) and (res_bin |-> !res_fdump));

  // R2: third-level control only during the photodiode transfer
  p_v3rd_quiet_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    v3rd_o |-> (vclk1_o && !vclk2_o && !hclk_en_o && !frame_sync_o));

  // R4: each second vertical clock pulse has the transfer length
  p_v2_len_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(vclk2_o) |-> (v2_run_q == VCCD_CNT));

  // R5: horizontal clocking never overlaps vertical or shutter activity
  p_h_quiet_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    hclk_en_o |-> (!vclk1_o && !vclk2_o && !shutter_o));

  // R8: line strobe only inside the frame strobe
  p_line_in_frame_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    line_sync_o |-> frame_sync_o);

  // R9: shutter pulse length and the idle delay after it
  p_shut_len_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(shutter_o) |-> (sh_run_q == SHUT_PULSE && !hclk_en_o));

  // R11: pixel strobe inside a line, halved in binning mode
  p_pix_in_line_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    pix_sync_o |-> line_sync_o);
  p_bin_pix_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_bin && pix_sync_o) |=> !pix_sync_o);

  // R12: no integration while photodiodes are emptied or shuttered
  p_integ_r12: assert property (@(posedge clk_i) disable iff (rst_i)
    (vclk1_o || shutter_o) |-> !integrate_o);

endmodule

bind ccd_frame_seq ccd_frame_seq_chk #(
  .VCCD_CNT(VCCD_CNT), .SHUT_PULSE(SHUT_PULSE)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .vclk1_o     (vclk1_o),
  .vclk2_o     (vclk2_o),
  .v3rd_o      (v3rd_o),
  .hclk_en_o   (hclk_en_o),
  .shutter_o   (shutter_o),
  .frame_sync_o(frame_sync_o),
  .line_sync_o (line_sync_o),
  .pix_sync_o  (pix_sync_o),
  .integrate_o (integrate_o),
  .res_dual    (res_mode.dual),
  .res_bin     (res_mode.bin),
  .res_fdump   (res_mode.fdump),
  .act_bin     (act_bin)
);

// File: tb/ccd_frame_seq_tb.sv
module ccd_frame_seq_tb;
  localparam int SETUP = 5, V3RD = 3, DELAY = 4;
  localparam int VDLY = 1, VCCD = 2, HDLY = 2;
  localparam int PIX = 8, LINES = 16, DUMP = 3;
  localparam int STEP = 2, SPULSE = 4, SDELAY = 2;
  localparam int DIODE_T = SETUP + V3RD + DELAY;
  localparam int VPER_T  = VDLY + VCCD + HDLY;
  localparam int SHUT_T  = SPULSE + SDELAY;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dual_sel = 1'b0, fdump_sel = 1'b0, bin_sel = 1'b0;
  logic [2:0] int_sel = 3'd0, shut_sel = 3'd0;
  logic vclk1, vclk2, v3rd, hclk_en, shutter, frame_sync, line_sync;
  logic pix_sync, integrate;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ccd_frame_seq #(
    .SETUP_CNT(SETUP), .V3RD_CNT(V3RD), .DELAY_CNT(DELAY),
    .VDLY_CNT(VDLY), .VCCD_CNT(VCCD), .HDLY_CNT(HDLY),
    .PIX_CNT(PIX), .LINES(LINES), .DUMP_LINES(DUMP),
    .SHUT_STEP(STEP), .SHUT_PULSE(SPULSE), .SHUT_DELAY(SDELAY)
  ) u_dut (
    .clk_i(clk), .rst_i(rst),
    .dual_sel_i(dual_sel), .fdump_sel_i(fdump_sel), .bin_sel_i(bin_sel),
    .int_sel_i(int_sel), .shut_sel_i(shut_sel),
    .vclk1_o(vclk1), .vclk2_o(vclk2), .v3rd_o(v3rd), .hclk_en_o(hclk_en),
    .shutter_o(shutter), .frame_sync_o(frame_sync),
    .line_sync_o(line_sync), .pix_sync_o(pix_sync),
    .integrate_o(integrate)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R8 watchdog: actual %0d cycles expected below %0d",
               cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13", "vclk1 in reset", int'(vclk1), 0);
    chk("R13", "vclk2 in reset", int'(vclk2), 0);
    chk("R13", "v3rd in reset", int'(v3rd), 0);
    chk("R13", "hclk_en in reset", int'(hclk_en), 0);
    chk("R13", "shutter in reset", int'(shutter), 0);
    chk("R13", "frame_sync in reset", int'(frame_sync), 0);
    chk("R13", "line_sync in reset", int'(line_sync), 0);
    chk("R13", "pix_sync in reset", int'(pix_sync), 0);
    chk("R12", "integrate in reset", int'(integrate), 0);
  endtask

  // Runs one scenario from reset and measures the window from one rise of
  // vclk1 to the next, which spans exactly N+1 frames.
  task automatic run_case(input string tag, input bit d, input bit f,
                          input bit b, input int n, input int m,
                          input bit flip);
    bit r_dual, r_bin, r_fd, sh;
    int k, rl, sl, rest, e_per, e_v2, e_lines, e_pix, e_sh, e_il;
    int period, v2p, v2h, lines, hc, pc, sc, v3c, il, first_sh;
    logic p_v1, p_v2, p_ln, p_sh;

    r_dual = d;
    r_bin  = b & ~d;
    r_fd   = f & ~r_bin;
    k      = (r_dual | r_bin) ? 2 : 1;
    rl     = (LINES - (r_fd ? 2 * DUMP : 0)) / k;
    sl     = m * STEP;
    sh     = (m != 0) && (sl < rl);
    rest   = (r_fd ? 2 * DUMP * VPER_T : 0) + rl * (k * VPER_T + PIX) +
             (sh ? SHUT_T : 0);
    e_per   = DIODE_T + (n + 1) * (1 + rest);
    e_v2    = (n + 1) * ((r_fd ? 2 * DUMP : 0) + rl * k);
    e_lines = (n + 1) * rl;
    e_pix   = e_lines * (r_bin ? PIX / 2 : PIX);
    e_sh    = (n + 1) * (sh ? SPULSE : 0);
    e_il    = DIODE_T + (n + 1) * (sh ? SHUT_T : 0);

    rst = 1'b1;
    dual_sel = d; fdump_sel = f; bin_sel = b;
    int_sel = 3'(n); shut_sel = 3'(m);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    p_v1 = 1'b0;
    forever begin
      @(negedge clk);
      if (vclk1 && !p_v1) break;
      p_v1 = vclk1;
    end
    if (flip) dual_sel = ~dual_sel;

    period = 0; v2p = 0; v2h = 0; lines = 0; hc = 0; pc = 0; sc = 0;
    v3c = 0; il = 0; first_sh = -1;
    p_v1 = 1'b1; p_v2 = 1'b0; p_ln = 1'b0; p_sh = 1'b0;
    forever begin
      period++;
      if (vclk2 && !p_v2) v2p++;
      if (vclk2) v2h++;
      if (line_sync && !p_ln) lines++;
      if (hclk_en) hc++;
      if (pix_sync) pc++;
      if (shutter) sc++;
      if (shutter && !p_sh && first_sh < 0) first_sh = lines;
      if (v3rd) v3c++;
      if (!integrate) il++;
      p_v2 = vclk2; p_ln = line_sync; p_sh = shutter;
      @(negedge clk);
      if (vclk1 && !p_v1) break;
      p_v1 = vclk1;
    end

    chk("R8", {tag, " frame period"}, period, e_per);
    chk("R6", {tag, " vertical periods"}, v2p, e_v2);
    chk("R4", {tag, " vclk2 high cycles"}, v2h, e_v2 * VCCD);
    chk("R5", {tag, " lines read"}, lines, e_lines);
    chk("R7", {tag, " hclk cycles"}, hc, e_lines * PIX);
    chk("R11", {tag, " pixel strobes"}, pc, e_pix);
    chk("R2", {tag, " v3rd cycles"}, v3c, V3RD);
    chk("R9", {tag, " shutter cycles"}, sc, e_sh);
    chk("R12", {tag, " integrate low cycles"}, il, e_il);
    chk("R10", {tag, " shutter line"}, first_sh, sh ? sl : -1);
  endtask

  task automatic t_single();     run_case("R5 single", 0, 0, 0, 0, 0, 0); endtask
  task automatic t_dual();       run_case("R6 dual", 1, 0, 0, 0, 0, 0); endtask
  task automatic t_bin();        run_case("R6 bin", 0, 0, 1, 0, 0, 0); endtask
  task automatic t_fdump();      run_case("R7 fdump", 0, 1, 0, 0, 0, 0); endtask
  task automatic t_all_three();  run_case("R1 all", 1, 1, 1, 0, 0, 0); endtask
  task automatic t_bin_fast();   run_case("R1 bin+fast", 0, 1, 1, 0, 0, 0); endtask
  task automatic t_bin_dual();   run_case("R1 bin+dual", 1, 0, 1, 0, 0, 0); endtask
  task automatic t_multi();      run_case("R3 multi", 0, 0, 0, 2, 0, 0); endtask
  task automatic t_shut_single(); run_case("R9 shut", 0, 0, 0, 0, 3, 0); endtask
  task automatic t_shut_dual_off(); run_case("R10 dual off", 1, 0, 0, 0, 4, 0); endtask
  task automatic t_shut_dual_on(); run_case("R9 dual on", 1, 0, 0, 0, 3, 0); endtask
  task automatic t_shut_fdump(); run_case("R9 fdump", 0, 1, 0, 0, 4, 0); endtask
  task automatic t_shut_multi(); run_case("R3 shut", 0, 0, 0, 1, 2, 0); endtask
  task automatic t_mode_hold();  run_case("R13 hold", 0, 0, 0, 0, 0, 1); endtask

  initial begin
    t_reset();
    t_single();
    t_dual();
    t_bin();
    t_fdump();
    t_all_three();
    t_bin_fast();
    t_bin_dual();
    t_multi();
    t_shut_single();
    t_shut_dual_off();
    t_shut_dual_on();
    t_shut_fdump();
    t_shut_multi();
    t_mode_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule